// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns a parallel character into an asynchronous serial frame on a single output line. The frame format comes from an 8-bit mode word: the number of data bits (5 to 8), whether a parity bit is added and whether it is odd or even, and the stop length (1, 1.5 or 2 bit times). The same word also selects how many input clocks make up one bit time: 1, 16 or 64. The mode word is sampled when each frame starts, so the format can change between characters.

A holding register sits in front of the shift stage. Software can write the next character while the current one is still being sent, and consecutive frames then leave the line with no idle gap between them. Two flags describe the buffer state: one shows that a new character may be written, and the other shows that the transmitter has nothing left to send. A transmit-enable input gates the start of every frame. A break input forces the line low for as long as it is held.

Top module: `async_tx`

## Requirements
- R1: After reset the line is high, tx_empty_o is 1, and tx_ready_o equals tx_en_i.
- R2: mode_i[1:0] sets the clocks per bit time: 01 gives 1, 10 gives 16, 11 gives 64. Every start, data and parity bit lasts exactly that many clocks.
- R3: mode_i[3:2] sets the character length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits. Data bits at or above that length are not sent.
- R4: mode_i[4] = 1 adds a parity bit right after the last data bit. mode_i[5] = 1 makes the count of ones across the data and parity bits even, and mode_i[5] = 0 makes it odd.
- R5: mode_i[7:6] sets the stop time: 01 = 1 bit time, 11 = 2 bit times, 10 = 1.5 bit times (24 clocks at x16, 96 at x64, 2 clocks at x1). The stop time is a high level.
- R6: A frame is a low start bit, then data bits LSB first, then parity, then stop. The line idles high. When a write is sampled at clock edge W and the transmitter is idle and enabled, the start bit appears after edge W+1.
- R7: A character written while a frame is shifting is held and sent directly after that frame's stop time ends, with no idle cycle in between.
- R8: tx_ready_o is 1 exactly when the holding register is empty and tx_en_i is 1.
- R9: tx_empty_o is 1 exactly when both the holding register and the shift stage are empty. It drops after the edge that samples a write and rises after the edge that ends the last stop time.
- R10: No frame starts while tx_en_i is 0, and a held character stays held. Its frame starts after the first edge that samples tx_en_i = 1.
- R11: While brk_i is sampled 1 at a clock edge, the line is low after that edge. After brk_i is released, an idle line reads high again from the next edge.
- R12: The format of a frame is fixed when the frame starts. A change of mode_i during the frame has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock (bit time is 1, 16 or 64 of these) |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 8 | Frame format word: factor [1:0], length [3:2], parity enable [4], even [5], stop [7:6] |
| tx_en_i | input | 1 | Transmit enable; frames start only while high |
| brk_i | input | 1 | Force the line low while high |
| wr_i | input | 1 | One-cycle strobe writing wr_data_i to the holding register |
| wr_data_i | input | 8 | Character to send |
| txd_o | output | 1 | Serial output line |
| tx_ready_o | output | 1 | Holding register empty and transmit enabled |
| tx_empty_o | output | 1 | Nothing held and nothing shifting |

## Verification
The main function is tried with a sweep over every character length, parity setting and stop code at both x1 and x16, using two data bytes whose bits above the shorter lengths differ. A mismatch therefore points to a wrong bit order, a wrong length cut, an inverted parity sense or a wrong stop count. Selected x64 frames cover the large divider, including the 96-clock half-stop case. Dedicated patterns cover back-to-back writes, writes held while transmit is disabled, a mode change in the middle of a frame, and break on an idle line. Each of these separates the buffering and gating behaviour from the frame shape.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int CHAR_MAX = 8;
  localparam int FRAME_W  = CHAR_MAX + 2;

  typedef enum logic [1:0] {
    FAC_NONE = 2'b00,
    FAC_X1   = 2'b01,
    FAC_MID  = 2'b10,
    FAC_HI   = 2'b11
  } fac_e;

  typedef enum logic [1:0] {
    STP_BAD  = 2'b00,
    STP_ONE  = 2'b01,
    STP_HALF = 2'b10,
    STP_TWO  = 2'b11
  } stop_e;
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_i) begin
        full_q <= 1'b1;
        data_q <= data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R7: a sampled write always leaves a character held
  p_write_fills_r7: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> full_q);
  // R10: a take without a write empties the register
  p_take_empties_r10: assert property (@(posedge clk) disable iff (rst)
    (take_i && !wr_i) |=> !full_q);
endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
  import tx_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64,
  parameter int CNT_W   = 8,
  parameter int NB_W    = 4
) (
  input  logic [7:0]          mode_i,
  input  logic [CHAR_MAX-1:0] data_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [NB_W-1:0]     nbits_o,
  output logic [CNT_W-1:0]    div_o,
  output logic [CNT_W-1:0]    stop_o
);
  logic [3:0]          clen;
  logic                par_en;
  logic                par_bit;
  logic [CHAR_MAX-1:0] mask;
  fac_e                fac;
  stop_e               stp;

  assign fac    = fac_e'(mode_i[1:0]);
  assign stp    = stop_e'(mode_i[7:6]);
  assign clen   = 4'd5 + {2'b00, mode_i[3:2]};
  assign par_en = mode_i[4];

  always_comb begin
    for (int i = 0; i < CHAR_MAX; i++) begin
      mask[i] = (i < int'(clen));
    end
  end

  assign par_bit = (^(data_i & mask)) ^ ~mode_i[5];

  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (mask[i]) frame_o[i+1] = data_i[i];
    end
    if (par_en) frame_o[int'(clen) + 1] = par_bit;
  end

  assign nbits_o = NB_W'(clen) + NB_W'(par_en) + NB_W'(1);

  always_comb begin
    unique case (fac)
      FAC_MID: div_o = CNT_W'(DIV_MID);
      FAC_HI:  div_o = CNT_W'(DIV_HI);
      default: div_o = CNT_W'(1);
    endcase
  end

  always_comb begin
    unique case (stp)
      STP_HALF: stop_o = (div_o == CNT_W'(1)) ? CNT_W'(2) : div_o + (div_o >> 1);
      STP_TWO:  stop_o = div_o << 1;
      default:  stop_o = div_o;
    endcase
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int FRAME_W = 10,
  parameter int CNT_W   = 8,
  parameter int NB_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold_full_i,
  input  logic               tx_en_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [NB_W-1:0]    nbits_i,
  input  logic [CNT_W-1:0]   div_i,
  input  logic [CNT_W-1:0]   stop_i,
  output logic               take_o,
  output logic               line_o,
  output logic               busy_o
);
  logic               busy_q, in_stop_q, line_q;
  logic [FRAME_W-1:0] sh_q;
  logic [NB_W-1:0]    left_q;
  logic [CNT_W-1:0]   rem_q, div_q, stop_q;
  logic               bit_end, frame_end;

  assign bit_end   = busy_q && (rem_q == '0);
  assign frame_end = bit_end && in_stop_q;
  assign take_o    = hold_full_i && tx_en_i && (!busy_q || frame_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      in_stop_q <= 1'b0;
      line_q    <= 1'b1;
      sh_q      <= '0;
      left_q    <= '0;
      rem_q     <= '0;
      div_q     <= CNT_W'(1);
      stop_q    <= CNT_W'(1);
    end else if (take_o) begin
      busy_q    <= 1'b1;
      in_stop_q <= 1'b0;
      line_q    <= frame_i[0];
      sh_q      <= frame_i >> 1;
      left_q    <= nbits_i - NB_W'(1);
      rem_q     <= div_i - CNT_W'(1);
      div_q     <= div_i;
      stop_q    <= stop_i;
    end else if (frame_end) begin
      busy_q    <= 1'b0;
      in_stop_q <= 1'b0;
      line_q    <= 1'b1;
    end else if (bit_end) begin
      if (left_q != '0) begin
        line_q <= sh_q[0];
        sh_q   <= sh_q >> 1;
        left_q <= left_q - NB_W'(1);
        rem_q  <= div_q - CNT_W'(1);
      end else begin
        line_q    <= 1'b1;
        in_stop_q <= 1'b1;
        rem_q     <= stop_q - CNT_W'(1);
      end
    end else if (busy_q) begin
      rem_q <= rem_q - CNT_W'(1);
    end
  end

  assign line_o = line_q;
  assign busy_o = busy_q;

  // R6: every frame opens with a low start bit
  p_start_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !line_q);
  // R6: an idle shift stage leaves the line high
  p_idle_high_r6: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> line_q);
  // R10: a frame only starts on a cycle that saw the enable
  p_start_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(tx_en_i));
  // R5: the stop interval is high throughout
  p_stop_high_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && in_stop_q) |-> line_q);
endmodule

// File: rtl/async_tx.sv
module async_tx
  import tx_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] mode_i,
  input  logic       tx_en_i,
  input  logic       brk_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic       txd_o,
  output logic       tx_ready_o,
  output logic       tx_empty_o
);
  localparam int CNT_W = $clog2(2 * DIV_HI + 1);
  localparam int NB_W  = $clog2(FRAME_W + 1);

  logic                hold_full, take, line, busy, brk_q;
  logic [CHAR_MAX-1:0] hold_data;
  logic [FRAME_W-1:0]  frame;
  logic [NB_W-1:0]     nbits;
  logic [CNT_W-1:0]    div, stop_len;

  tx_hold_reg #(.DATA_W(CHAR_MAX)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (wr_i),
    .data_i (wr_data_i),
    .take_i (take),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  tx_frame_build #(
    .DIV_MID (DIV_MID),
    .DIV_HI  (DIV_HI),
    .CNT_W   (CNT_W),
    .NB_W    (NB_W)
  ) u_build (
    .mode_i  (mode_i),
    .data_i  (hold_data),
    .frame_o (frame),
    .nbits_o (nbits),
    .div_o   (div),
    .stop_o  (stop_len)
  );

  tx_shifter #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W),
    .NB_W    (NB_W)
  ) u_shift (
    .clk         (clk),
    .rst         (rst),
    .hold_full_i (hold_full),
    .tx_en_i     (tx_en_i),
    .frame_i     (frame),
    .nbits_i     (nbits),
    .div_i       (div),
    .stop_i      (stop_len),
    .take_o      (take),
    .line_o      (line),
    .busy_o      (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= brk_i;
  end

  assign txd_o      = line & ~brk_q;
  assign tx_ready_o = ~hold_full & tx_en_i;
  assign tx_empty_o = ~hold_full & ~busy;

  // R11: a sampled break holds the line low after the edge
  p_break_low_r11: assert property (@(posedge clk) disable iff (rst)
    brk_i |=> !txd_o);
  // R9: with nothing to send, only a break can pull the line low
  p_empty_line_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_empty_o && !brk_q) |-> txd_o);
  // R8: a write drops the ready flag after the edge
  p_write_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> !tx_ready_o);
endmodule

// File: tb/async_tx_bench.sv
module async_tx_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mode = 8'h4D;
  logic       en = 1'b1;
  logic       brk = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       txd, rdy, emp;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_tx u_async_tx (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .tx_en_i    (en),
    .brk_i      (brk),
    .wr_i       (wr),
    .wr_data_i  (wdata),
    .txd_o      (txd),
    .tx_ready_o (rdy),
    .tx_empty_o (emp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int f_div(input logic [7:0] m);
    case (m[1:0])
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 1;
    endcase
  endfunction

  function automatic int f_stop(input logic [7:0] m);
    int d = f_div(m);
    case (m[7:6])
      2'b10:   return (d == 1) ? 2 : (d * 3) / 2;
      2'b11:   return 2 * d;
      default: return d;
    endcase
  endfunction

  function automatic int f_clen(input logic [7:0] m);
    return 5 + int'(m[3:2]);
  endfunction

  function automatic int f_total(input logic [7:0] m);
    return (1 + f_clen(m) + int'(m[4])) * f_div(m) + f_stop(m);
  endfunction

  function automatic logic f_exp(input logic [7:0] m, input logic [7:0] d, input int t);
    int idx = t / f_div(m);
    int cl  = f_clen(m);
    int ones = 0;
    if (idx == 0) return 1'b0;
    if (idx <= cl) return d[idx-1];
    if (m[4] && idx == cl + 1) begin
      for (int i = 0; i < cl; i++) ones += int'(d[i]);
      return m[5] ? logic'(ones % 2) : logic'((ones + 1) % 2);
    end
    return 1'b1;
  endfunction

  // write one char; optionally change mode at cycle chg_at of the frame
  task automatic send_frame(input logic [7:0] m, input logic [7:0] d, input string req,
                            input int chg_at, input logic [7:0] m2);
    int total = f_total(m);
    @(negedge clk); mode = m; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    check(emp == 1'b0, "R9", int'(emp), 0);
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      check(txd == f_exp(m, d, t), req, int'(txd), int'(f_exp(m, d, t)));
      if (t == 0) check(rdy == 1'b1, "R8", int'(rdy), 1);
      if (t == chg_at) mode = m2;
    end
    @(negedge clk);
    check(emp == 1'b1, "R9", int'(emp), 1);
    check(txd == 1'b1, "R6", int'(txd), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(txd == 1'b1, "R1", int'(txd), 1);
    check(emp == 1'b1, "R1", int'(emp), 1);
    check(rdy == 1'b1, "R1", int'(rdy), 1);

    // R2 R3 R4 R5 R6: sweep at x1 and x16
    for (int f = 1; f <= 2; f++)
      for (int cl = 0; cl < 4; cl++)
        for (int p = 0; p < 3; p++)
          for (int s = 1; s < 4; s++)
            for (int k = 0; k < 2; k++) begin
              logic [7:0] m;
              m = {2'(s), (p == 2) ? 1'b1 : 1'b0, (p != 0) ? 1'b1 : 1'b0, 2'(cl), 2'(f)};
              send_frame(m, (k == 0) ? 8'hA5 : 8'h3C, "R3/R4/R5 sweep", -1, 8'h00);
            end

    // R2 R5: x64 with half and double stop
    send_frame(8'b10_1_1_11_11, 8'h96, "R2 x64 stop 1.5", -1, 8'h00);
    send_frame(8'b11_0_1_01_11, 8'h2B, "R5 x64 stop 2", -1, 8'h00);

    // R12: mode change during a frame
    send_frame(8'b01_0_1_11_10, 8'hC3, "R12", 20, 8'b11_1_0_00_01);

    // R7: second write while first frame shifts
    begin
      logic [7:0] m = 8'b10_1_1_11_01;
      int t1 = f_total(m);
      @(negedge clk); mode = m; wdata = 8'h5A; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      for (int t = 0; t < 2 * t1; t++) begin
        logic e;
        @(negedge clk);
        e = (t < t1) ? f_exp(m, 8'h5A, t) : f_exp(m, 8'hE1, t - t1);
        check(txd == e, "R7", int'(txd), int'(e));
        if (t == 3) check(rdy == 1'b0, "R8", int'(rdy), 0);
        if (t == t1) check(rdy == 1'b1, "R8", int'(rdy), 1);
        if (t == t1) check(emp == 1'b0, "R9", int'(emp), 0);
        if (t == 2) begin wdata = 8'hE1; wr = 1'b1; end
        if (t == 3) wr = 1'b0;
      end
      @(negedge clk);
      check(emp == 1'b1, "R9", int'(emp), 1);
    end

    // R10: write held while disabled
    begin
      logic [7:0] m = 8'b01_0_0_10_10;
      @(negedge clk); en = 1'b0; mode = m; wdata = 8'h4F; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        check(txd == 1'b1, "R10", int'(txd), 1);
        if (t == 0) check(rdy == 1'b0, "R8", int'(rdy), 0);
        if (t == 0) check(emp == 1'b0, "R10", int'(emp), 0);
      end
      en = 1'b1;
      for (int t = 0; t < f_total(m); t++) begin
        @(negedge clk);
        check(txd == f_exp(m, 8'h4F, t), "R10", int'(txd), int'(f_exp(m, 8'h4F, t)));
      end
      @(negedge clk);
      check(emp == 1'b1, "R9", int'(emp), 1);
    end

    // R11: break on idle line
    @(negedge clk); brk = 1'b1;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      check(txd == 1'b0, "R11", int'(txd), 0);
    end
    brk = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R11", int'(txd), 1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule